// File: doc/BRIEF.md
# Tower-Field Byte Substitution Unit

This block performs the AES byte substitution or its inverse on one byte per clock without any lookup table. A single mode input selects the direction. In both directions the multiplicative inverse in GF(2^8) comes from one shared inverter that works in a tower of small fields. A linear change of basis takes the byte into a degree-two extension over GF(16), where GF(16) is itself built over GF(4). The inversion then runs in that tower, and a second linear map brings the result back to the AES polynomial basis. The affine steps are placed on either side of this shared core: the forward affine step comes after the core, and the inverse affine step comes before it.

The tower polynomials are chosen while the design is elaborated. The GF(4)-over-GF(16) constant is a parameter. The GF(16) extension constant is the first one that makes its quadratic irreducible. The basis-change matrices are derived from a root of the AES field polynomial found inside the tower. Because of this, no hand-copied matrix can disagree with the arithmetic. A parameter places zero, one or two register stages: the first after the downward map, the second after the inversion. This lets a round datapath trade latency for clock rate. The mode bit travels through the pipeline with its byte.

Top module: `sbox_tower`

## Requirements
- R1: With `fwd_mode` = 1, `dout` equals the AES SubBytes value of the byte presented PIPE rising edges earlier, for all 256 inputs.
- R2: With `fwd_mode` = 0, `dout` equals the AES InvSubBytes value of the byte presented PIPE rising edges earlier, for all 256 inputs.
- R3: The zero element is handled as an inverse of zero: a forward input of 0x00 gives 0x63, and an inverse input of 0x63 gives 0x00.
- R4: A new byte and mode are accepted on every cycle. The mode is carried with its own byte, so changing direction from one cycle to the next does not disturb bytes already in flight. An input held steady gives a steady output.
- R5: The reset `rst_n` is synchronous and active low. With PIPE of 1 or more, `dout` reads 0x00 from the first rising edge that samples `rst_n` low until new bytes reach the output after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_mode | input | 1 | 1 selects forward substitution, 0 selects inverse |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte, PIPE cycles after `din` |

## Verification
Each result is due PIPE rising edges after its byte and mode are applied; with the default PIPE of 2, a byte driven on one falling edge is compared two falling edges later. The bench keeps a queue of expected bytes, one entry pushed per driven cycle, and pops the head only once the queue is as deep as the latency. It samples `dout` on the falling edge, before the next byte is driven, so every comparison lands on the cycle in which that byte's result is on the port. When reset is asserted mid-stream, the queue is emptied and the zero output is checked from the falling edge after the first reset edge.

// File: rtl/sbox_tower_pkg.sv
// Package: tower-field arithmetic for the byte substitution unit.
// Holds GF(4), GF(16) and GF(256)-in-tower operations, plus constant
// functions that pick the extension constant and derive the basis-change
// columns at elaboration. Tower element layout: {high coeff, low coeff},
// GF(4) as b1*w+b0 with w^2 = w+1.
package sbox_tower_pkg;

    localparam int BYTE_W = 8;

    // GF(4) product in basis {w,1}.
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        logic hh;
        hh = a[1] & b[1];
        return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
    endfunction

    // GF(16) product over GF(4), y^2 = y + phi.
    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b,
                                            input logic [1:0] phi);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                gf4_mul(hh, phi) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    // GF(16) inverse; the GF(4) inverse is a squaring. Zero maps to zero.
    function automatic logic [3:0] gf16_inv(input logic [3:0] a, input logic [1:0] phi);
        logic [1:0] d;
        logic [1:0] di;
        d  = gf4_mul(gf4_mul(a[3:2], a[3:2]), phi) ^ gf4_mul(a[1:0], a[3:2] ^ a[1:0]);
        di = gf4_mul(d, d);
        return {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
    endfunction

    // GF(256) product in the tower, z^2 = z + lambda (elaboration use).
    function automatic logic [7:0] gf256_mul(input logic [7:0] a, input logic [7:0] b,
                                             input logic [1:0] phi, input logic [3:0] lam);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4], phi);
        return {hh ^ gf16_mul(a[7:4], b[3:0], phi) ^ gf16_mul(a[3:0], b[7:4], phi),
                gf16_mul(hh, lam, phi) ^ gf16_mul(a[3:0], b[3:0], phi)};
    endfunction

    // First lambda for which z^2 + z + lambda has no root in GF(16).
    function automatic logic [3:0] find_lambda(input logic [1:0] phi);
        logic [3:0] pick;
        logic       found;
        logic       irr;
        pick  = 4'h0;
        found = 1'b0;
        for (int l = 1; l < 16; l++) begin
            irr = 1'b1;
            for (int z = 0; z < 16; z++) begin
                if ((gf16_mul(4'(z), 4'(z), phi) ^ 4'(z) ^ 4'(l)) == 4'h0) irr = 1'b0;
            end
            if (irr && !found) begin
                pick  = 4'(l);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    // Columns of the map AES basis -> tower: column i is beta^i, where beta
    // is the first tower root of x^8 + x^4 + x^3 + x + 1.
    function automatic logic [63:0] build_map_cols(input logic [1:0] phi, input logic [3:0] lam);
        logic [7:0]  beta;
        logic [7:0]  b2;
        logic [7:0]  b4;
        logic [7:0]  p;
        logic [7:0]  pw;
        logic [63:0] cols;
        logic        found;
        beta  = 8'h02;
        found = 1'b0;
        for (int c = 2; c < 256; c++) begin
            b2 = gf256_mul(8'(c), 8'(c), phi, lam);
            b4 = gf256_mul(b2, b2, phi, lam);
            p  = gf256_mul(b4, b4, phi, lam) ^ b4 ^ gf256_mul(b2, 8'(c), phi, lam)
                 ^ 8'(c) ^ 8'h01;
            if (p == 8'h00 && !found) begin
                beta  = 8'(c);
                found = 1'b1;
            end
        end
        pw   = 8'h01;
        cols = '0;
        for (int i = 0; i < 8; i++) begin
            cols[8*i +: 8] = pw;
            pw = gf256_mul(pw, beta, phi, lam);
        end
        return cols;
    endfunction

    // GF(2) matrix-by-vector with the matrix held as eight byte columns.
    function automatic logic [7:0] apply_cols(input logic [63:0] cols, input logic [7:0] x);
        logic [7:0] y;
        y = '0;
        for (int i = 0; i < 8; i++) begin
            if (x[i]) y = y ^ cols[8*i +: 8];
        end
        return y;
    endfunction

    // Inverse basis change: column j is the AES byte whose image is bit j.
    function automatic logic [63:0] build_unmap_cols(input logic [63:0] map_cols);
        logic [63:0] cols;
        cols = '0;
        for (int j = 0; j < 8; j++) begin
            for (int a = 1; a < 256; a++) begin
                if (apply_cols(map_cols, 8'(a)) == 8'(1 << j)) cols[8*j +: 8] = 8'(a);
            end
        end
        return cols;
    endfunction

    // Rotate a byte toward the MSB by k positions.
    function automatic logic [7:0] rotl8(input logic [7:0] a, input int k);
        return 8'((a << k) | (a >> (8 - k)));
    endfunction

endpackage

// File: rtl/sbox_gf_lin.sv
// Module: fixed 8x8 GF(2) linear map given as eight byte columns.
// Assumes COLS is a constant; the result is an XOR tree, no state.
module sbox_gf_lin
    import sbox_tower_pkg::*;
#(
    parameter logic [63:0] COLS = 64'h8040201008040201
) (
    input  logic [BYTE_W-1:0] x,
    output logic [BYTE_W-1:0] y
);
    logic [BYTE_W-1:0] term [BYTE_W];

    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_term
        assign term[gi] = x[gi] ? COLS[BYTE_W*gi +: BYTE_W] : '0;
    end

    // Fold the selected columns into one byte.
    always_comb begin
        y = '0;
        for (int i = 0; i < BYTE_W; i++) y = y ^ term[i];
    end
endmodule

// File: rtl/sbox_affine.sv
// Module: AES affine step in one direction chosen by INVERSE.
// INVERSE=0: circulant with taps 0..4 plus 0x63 (applied after inversion).
// INVERSE=1: circulant with taps 1,3,6 plus 0x05 (applied before inversion).
module sbox_affine
    import sbox_tower_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] y
);
    if (INVERSE) begin : g_inv
        // Undo the forward affine step.
        assign y = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    end else begin : g_fwd
        // Forward affine step.
        assign y = a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ 8'h63;
    end
endmodule

// File: rtl/sbox_tower_inv.sv
// Module: multiplicative inverse of a tower-field byte {h,l} = h*z + l,
// z^2 = z + LAMBDA over GF(16). Uses inv = h/d * z + (h+l)/d with
// d = h^2*LAMBDA + l*(h+l). Zero maps to zero. Purely combinational.
module sbox_tower_inv
    import sbox_tower_pkg::*;
#(
    parameter logic [1:0] PHI    = 2'b10,
    parameter logic [3:0] LAMBDA = 4'hC
) (
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] y
);
    logic [3:0] hi, lo, hl, d, d_inv;

    // Norm-like term and its GF(16) inverse, then the two output halves.
    always_comb begin
        hi    = a[7:4];
        lo    = a[3:0];
        hl    = hi ^ lo;
        d     = gf16_mul(gf16_mul(hi, hi, PHI), LAMBDA, PHI) ^ gf16_mul(lo, hl, PHI);
        d_inv = gf16_inv(d, PHI);
        y     = {gf16_mul(hi, d_inv, PHI), gf16_mul(hl, d_inv, PHI)};
    end
endmodule

// File: rtl/sbox_tower.sv
// Module: forward/inverse AES byte substitution through one shared tower
// inverter. Inverse mode: inverse affine, map down, invert, map up.
// Forward mode: map down, invert, map up, forward affine.
// PIPE (0..2) places registers after the downward map and after the
// inversion; the mode bit moves with its byte. Reset is synchronous, low.
module sbox_tower
    import sbox_tower_pkg::*;
#(
    parameter int         PIPE = 2,
    parameter logic [1:0] PHI  = 2'b10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fwd_mode,
    input  logic [7:0]  din,
    output logic [7:0]  dout
);
    localparam logic [3:0]  LAMBDA     = find_lambda(PHI);
    localparam logic [63:0] MAP_COLS   = build_map_cols(PHI, LAMBDA);
    localparam logic [63:0] UNMAP_COLS = build_unmap_cols(MAP_COLS);

    logic [BYTE_W-1:0] din_iaff, pre_map, tw_in, s1_tw, tw_inv, s2_tw, aes_inv, out_faff;
    logic              s1_fwd, s2_fwd;

    sbox_affine #(.INVERSE(1'b1)) u_iaff (.a(din), .y(din_iaff));

    // Inverse direction removes the affine step before inversion.
    always_comb pre_map = fwd_mode ? din : din_iaff;

    sbox_gf_lin #(.COLS(MAP_COLS)) u_map (.x(pre_map), .y(tw_in));

    if (PIPE >= 1) begin : g_reg_map
        // Stage register after the downward basis change.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_tw  <= '0;
                s1_fwd <= 1'b0;
            end else begin
                s1_tw  <= tw_in;
                s1_fwd <= fwd_mode;
            end
        end
    end else begin : g_wire_map
        assign s1_tw  = tw_in;
        assign s1_fwd = fwd_mode;
    end

    sbox_tower_inv #(.PHI(PHI), .LAMBDA(LAMBDA)) u_inv (.a(s1_tw), .y(tw_inv));

    if (PIPE >= 2) begin : g_reg_inv
        // Stage register after the shared inverter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s2_tw  <= '0;
                s2_fwd <= 1'b0;
            end else begin
                s2_tw  <= tw_inv;
                s2_fwd <= s1_fwd;
            end
        end
    end else begin : g_wire_inv
        assign s2_tw  = tw_inv;
        assign s2_fwd = s1_fwd;
    end

    sbox_gf_lin #(.COLS(UNMAP_COLS)) u_unmap (.x(s2_tw), .y(aes_inv));

    sbox_affine #(.INVERSE(1'b0)) u_faff (.a(aes_inv), .y(out_faff));

    // Forward direction finishes with the affine step.
    always_comb dout = s2_fwd ? out_faff : aes_inv;
endmodule

// File: rtl/sbox_tower_chk.sv
// Module: property checker for sbox_tower, bound to every instance.
// Keeps its own PIPE-deep history of din/mode to line inputs up with dout.
module sbox_tower_chk #(
    parameter int PIPE = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_mode,
    input logic [7:0] din,
    input logic [7:0] dout
);
    logic [7:0] hist_din;
    logic       hist_fwd;
    logic       hist_ok;
    logic       rst_low_q;

    if (PIPE == 0) begin : g_nohist
        assign hist_din = din;
        assign hist_fwd = fwd_mode;
        assign hist_ok  = 1'b1;
    end else begin : g_hist
        logic [7:0] d_q [PIPE];
        logic       m_q [PIPE];
        logic       v_q [PIPE];
        // Delay line matching the datapath latency.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < PIPE; i++) begin
                    d_q[i] <= '0;
                    m_q[i] <= 1'b0;
                    v_q[i] <= 1'b0;
                end
            end else begin
                d_q[0] <= din;
                m_q[0] <= fwd_mode;
                v_q[0] <= 1'b1;
                for (int i = 1; i < PIPE; i++) begin
                    d_q[i] <= d_q[i-1];
                    m_q[i] <= m_q[i-1];
                    v_q[i] <= v_q[i-1];
                end
            end
        end
        assign hist_din = d_q[PIPE-1];
        assign hist_fwd = m_q[PIPE-1];
        assign hist_ok  = v_q[PIPE-1];
    end

    // Remember that the previous edge saw reset.
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    a_r3_zero_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && hist_fwd && hist_din == 8'h00) |-> dout == 8'h63);

    a_r3_zero_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !hist_fwd && hist_din == 8'h63) |-> dout == 8'h00);

    a_r1_no_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && hist_fwd) |-> (dout != hist_din && dout != ~hist_din));

    a_r2_no_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !hist_fwd) |-> (dout != hist_din && dout != ~hist_din));

    a_r4_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(hist_ok) && hist_din == $past(hist_din)
         && hist_fwd == $past(hist_fwd)) |-> $stable(dout));

    if (PIPE > 0) begin : g_rst_chk
        a_r5_reset_clears: assert property (@(posedge clk)
            rst_low_q |-> dout == 8'h00);
    end
endmodule

bind sbox_tower sbox_tower_chk #(.PIPE(PIPE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_mode (fwd_mode),
    .din      (din),
    .dout     (dout)
);

// File: tb/test_sbox_tower.sv
// Bench: reference S-box from GF(2^8) exponentiation, expected-value queue
// sized to the pipeline latency, comparison on every falling edge.
module test_sbox_tower;
    localparam int CLK_PERIOD = 10;
    localparam int PIPE       = 2;
    localparam int DEPTH      = (PIPE == 0) ? 1 : PIPE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_mode = 1'b1;
    logic [7:0] din = 8'h53;
    logic [7:0] dout;

    int checks = 0;
    int failures = 0;

    logic [7:0] sb  [256];
    logic [7:0] isb [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    sbox_tower #(.PIPE(PIPE)) i_sbox_tower (
        .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode), .din(din), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] xmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
        end
        return acc;
    endfunction

    task automatic build_ref();
        int         lg [256];
        logic [7:0] ex [256];
        logic [7:0] v;
        logic [7:0] inv;
        logic [7:0] c = 8'h63;
        ex[0] = 8'h01;
        for (int i = 1; i < 256; i++) ex[i] = xmul(ex[i-1], 8'h03);
        for (int i = 0; i < 255; i++) lg[ex[i]] = i;
        for (int x = 0; x < 256; x++) begin
            inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
            for (int i = 0; i < 8; i++)
                v[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                       ^ inv[(i+7)%8] ^ c[i];
            sb[x] = v;
        end
        for (int x = 0; x < 256; x++) isb[sb[x]] = 8'(x);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: dout=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pop_check();
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, dout, e);
    endtask

    // One cycle: check the due result, then drive and record the next byte.
    task automatic step(input logic m, input logic [7:0] x, input string tag);
        @(negedge clk);
        if (exp_q.size() >= DEPTH) pop_check();
        fwd_mode = m;
        din      = x;
        if (m && x == 8'h00)       tag = "R3";
        else if (!m && x == 8'h63) tag = "R3";
        exp_q.push_back(m ? sb[x] : isb[x]);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) begin
            @(negedge clk);
            pop_check();
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        build_ref();
        // R5: output cleared while reset is held, whatever the inputs.
        repeat (3) begin
            @(negedge clk);
            if (PIPE > 0) chk("R5", dout, 8'h00);
        end
        rst_n = 1'b1;
        // R1: forward sweep of every byte.
        for (int x = 0; x < 256; x++) step(1'b1, 8'(x), "R1");
        // R2: inverse sweep of every byte.
        for (int x = 0; x < 256; x++) step(1'b0, 8'(x), "R2");
        // R4: mode flips every cycle with a scrambled byte order.
        for (int i = 0; i < 256; i++) step(i[0], 8'((i * 37 + 11) & 255), "R4");
        // R4: byte and mode held steady.
        for (int i = 0; i < 6; i++) step(1'b1, 8'hA7, "R4");
        for (int i = 0; i < 6; i++) step(1'b0, 8'hA7, "R4");
        drain();
        // R5: reset mid-stream flushes the pipeline to zero.
        for (int i = 0; i < 4; i++) step(1'b1, 8'(i + 200), "R1");
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        tag_q.delete();
        fwd_mode = 1'b1;
        din = 8'h00;
        repeat (2) begin
            @(negedge clk);
            if (PIPE > 0) chk("R5", dout, 8'h00);
        end
        rst_n = 1'b1;
        // R3: zero element in both directions after the flush.
        step(1'b1, 8'h00, "R3");
        step(1'b0, 8'h63, "R3");
        step(1'b1, 8'h53, "R1");
        step(1'b0, 8'hED, "R2");
        drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule